// File: doc/BRIEF.md
# Predicated element write controller

This block decides, element by element, what happens to the destination register of a vector instruction. It takes the active vector length, the current maximum vector length, a one-bit predicate selector from the instruction and the contents of the two predicate registers that the selector can name. From these it gives each element one of three actions: write the computed result, write zero, or leave the element untouched. Elements that are switched off by the predicate, and elements in the tail between the active length and the maximum length, are forced to zero rather than kept. When the active length is zero, nothing is touched.

The block also holds the predicate-count register, which sets how many predicate registers are enabled (0 to the parameter maximum). A legal write to it produces one-cycle pulses on the following cycle. These pulses clear all data registers, set every bit of the newly enabled predicate registers and load the vector length with its maximum. A combinational illegal-instruction flag covers three cases: an out-of-range count write, and two predicate accesses that are not allowed while the count is zero. While the flag is high, every element action is forced to keep.

Top module: `pred_write_ctrl`

## Requirements
- R1: When `pred_rd` is 1, `psel`=0 takes the element mask from `pred0` and `psel`=1 takes it from `pred1`. When `pred_rd` is 0, every element is treated as enabled.
- R2: An element below the effective active length whose mask bit is 0 gets action 10 (write zero). Action codes sit at `act[2i+1:2i]`: 00 keep, 01 write result, 10 write zero.
- R3: When the effective active length is nonzero, an element with index from the effective active length up to the effective maximum length minus one gets action 10. The effective maximum length is min(`mvl`, NELEM) and the effective active length is min(`vl`, effective maximum length).
- R4: When the effective active length is 0, every element gets action 00.
- R5: An element whose index is at or above the effective maximum length always gets action 00.
- R6: An element below the effective active length whose mask bit is 1 gets action 01.
- R7: `pcnt` resets to 0. A write through `cnt_wr` with `cnt_wdata` no greater than NPREG (8) is stored at the next edge. A larger value raises `illegal` in the same cycle and leaves `pcnt` unchanged.
- R8: While `pcnt` is 0, a predicate read with `psel`=0 returns all ones, a predicate read with `psel`=1 raises `illegal`, and any predicate write (`pred_wr`) raises `illegal`.
- R9: In the cycle after a legal count write, `clr_data`, `set_pred` and `load_vl` are 1 and `set_pred_mask` has bit j set exactly when j is below the new count. In every other cycle these pulses are 0 and the mask is 0.
- R10: While `illegal` is 1, every element gets action 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vl | input | LW (5) | Active vector length |
| mvl | input | LW (5) | Current maximum vector length |
| psel | input | 1 | Instruction predicate selector |
| pred0 | input | NELEM | First predicate register contents |
| pred1 | input | NELEM | Second predicate register contents |
| pred_rd | input | 1 | Instruction reads the selected predicate register |
| pred_wr | input | 1 | Instruction writes a predicate register |
| cnt_wr | input | 1 | Write strobe for the predicate count |
| cnt_wdata | input | CW (4) | Value written to the predicate count |
| act | output | 2*NELEM | Per-element action codes |
| illegal | output | 1 | Illegal-instruction flag |
| pcnt | output | CW (4) | Current predicate count |
| clr_data | output | 1 | Pulse: zero all data registers |
| set_pred | output | 1 | Pulse: set enabled predicate registers |
| load_vl | output | 1 | Pulse: load vector length with its maximum |
| set_pred_mask | output | NPREG | Predicate registers to set with the pulse |

## Verification
The assertions assume that every input holds a known value from the first clock after reset, and that a count write and its data are stable around the sampling edge. The stimulus changes inputs only on the falling edge. It keeps `vl` at or below `mvl`, and it lets `mvl` range above NELEM so that the clamp is exercised. Count writes are sparse and use values on both sides of the legal limit. This means the zero-count rules, the pulses and the illegal cases all occur, and they are interleaved with ordinary predicated traffic.

// File: rtl/pred_write_ctrl.sv
module pred_write_ctrl #(
  parameter int NELEM = 16,
  parameter int NPREG = 8,
  localparam int LW = $clog2(NELEM + 1),
  localparam int CW = $clog2(NPREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LW-1:0]      vl,
  input  logic [LW-1:0]      mvl,
  input  logic               psel,
  input  logic [NELEM-1:0]   pred0,
  input  logic [NELEM-1:0]   pred1,
  input  logic               pred_rd,
  input  logic               pred_wr,
  input  logic               cnt_wr,
  input  logic [CW-1:0]      cnt_wdata,
  output logic [2*NELEM-1:0] act,
  output logic               illegal,
  output logic [CW-1:0]      pcnt,
  output logic               clr_data,
  output logic               set_pred,
  output logic               load_vl,
  output logic [NPREG-1:0]   set_pred_mask
);

  localparam logic [1:0] ACT_KEEP = 2'b00;
  localparam logic [1:0] ACT_WR   = 2'b01;
  localparam logic [1:0] ACT_ZERO = 2'b10;

  logic [CW-1:0]    pcnt_q;
  logic             pulse_q;
  logic [NPREG-1:0] pen_q;
  logic [NPREG-1:0] pen_next;
  logic [NELEM-1:0] mask;
  logic [LW-1:0]    mvl_eff;
  logic [LW-1:0]    vl_eff;

  wire cnt_bad = cnt_wr && (cnt_wdata > CW'(NPREG));
  wire cnt_ok  = cnt_wr && !cnt_bad;
  wire no_pred = (pcnt_q == '0);

  assign illegal = cnt_bad || (no_pred && pred_rd && psel) || (no_pred && pred_wr);

  assign mvl_eff = (mvl > LW'(NELEM)) ? LW'(NELEM) : mvl;
  assign vl_eff  = (vl > mvl_eff) ? mvl_eff : vl;

  always_comb begin
    if (!pred_rd)     mask = '1;
    else if (psel)    mask = pred1;
    else if (no_pred) mask = '1;
    else              mask = pred0;
  end

  always_comb begin
    for (int j = 0; j < NPREG; j++)
      pen_next[j] = (CW'(j) < cnt_wdata);
  end

  for (genvar i = 0; i < NELEM; i++) begin : g_elem
    always_comb begin
      if (illegal || vl_eff == '0 || LW'(i) >= mvl_eff) act[2*i +: 2] = ACT_KEEP;
      else if (LW'(i) >= vl_eff)                         act[2*i +: 2] = ACT_ZERO;
      else if (!mask[i])                                  act[2*i +: 2] = ACT_ZERO;
      else                                                act[2*i +: 2] = ACT_WR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
      pen_q   <= '0;
    end else begin
      pulse_q <= cnt_ok;
      if (cnt_ok) begin
        pcnt_q <= cnt_wdata;
        pen_q  <= pen_next;
      end
    end
  end

  assign pcnt          = pcnt_q;
  assign clr_data      = pulse_q;
  assign set_pred      = pulse_q;
  assign load_vl       = pulse_q;
  assign set_pred_mask = pulse_q ? pen_q : '0;

  a_r10_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (act == '0));

  a_r4_zero_len_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (vl == '0) |-> (act == '0));

  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= CW'(NPREG));

  a_r7_bad_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_wdata > CW'(NPREG)) |=> $stable(pcnt));

  a_r9_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !(cnt_wdata > CW'(NPREG))) |=> (clr_data && load_vl && pcnt == $past(cnt_wdata)));

  a_r9_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (!clr_data && !set_pred && set_pred_mask == '0));

  a_r8_write_needs_preds: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt == '0 && pred_wr) |-> illegal);

endmodule

// File: tb/sim_pred_write_ctrl.sv
module sim_pred_write_ctrl;
  localparam int PERIOD = 10;
  localparam int N  = 16;
  localparam int NP = 8;
  localparam int LW = $clog2(N + 1);
  localparam int CW = $clog2(NP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] vl = '0, mvl = '0;
  logic psel = 1'b0, pred_rd = 1'b0, pred_wr = 1'b0, cnt_wr = 1'b0;
  logic [N-1:0] pred0 = '0, pred1 = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [2*N-1:0] act;
  logic illegal, clr_data, set_pred, load_vl;
  logic [CW-1:0] pcnt;
  logic [NP-1:0] set_pred_mask;

  int total = 0, bad = 0;
  int m_pcnt = 0;
  bit m_pulse = 0;
  int m_newcnt = 0;

  always #(PERIOD/2) clk = ~clk;

  pred_write_ctrl u0 (.*);

  task automatic chk(bit ok, string req, string what, longint act_v, longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic compare();
    int me, ve, iv;
    bit e_ill;
    int mk;
    logic [2*N-1:0] e_act;
    logic [NP-1:0] e_mask;
    string tg;
    string elem_tag [N];
    bit mismatch;
    e_ill = 0; tg = "R7";
    if (cnt_wr && cnt_wdata > NP) e_ill = 1;
    if (m_pcnt == 0 && pred_rd && psel) begin e_ill = 1; tg = "R8"; end
    if (m_pcnt == 0 && pred_wr) begin e_ill = 1; tg = "R8"; end
    chk(illegal == e_ill, tg, "illegal", illegal, e_ill);
    me = (mvl > N) ? N : mvl;
    ve = (vl > me) ? me : vl;
    for (int i = 0; i < N; i++) begin
      if (!pred_rd) mk = 1;
      else if (psel) mk = pred1[i];
      else if (m_pcnt == 0) mk = 1;
      else mk = pred0[i];
      if (e_ill) begin e_act[2*i +: 2] = 2'b00; elem_tag[i] = "R10"; end
      else if (ve == 0) begin e_act[2*i +: 2] = 2'b00; elem_tag[i] = "R4"; end
      else if (i >= me) begin e_act[2*i +: 2] = 2'b00; elem_tag[i] = "R5"; end
      else if (i >= ve) begin e_act[2*i +: 2] = 2'b10; elem_tag[i] = "R3"; end
      else if (mk == 0) begin e_act[2*i +: 2] = 2'b10; elem_tag[i] = pred_rd ? "R1/R2" : "R2"; end
      else begin e_act[2*i +: 2] = 2'b01; elem_tag[i] = (pred_rd && m_pcnt == 0) ? "R8" : "R6"; end
    end
    mismatch = 0;
    for (int i = 0; i < N; i++)
      if (!mismatch && act[2*i +: 2] !== e_act[2*i +: 2]) begin
        mismatch = 1;
        chk(0, elem_tag[i], $sformatf("act[%0d]", i), act[2*i +: 2], e_act[2*i +: 2]);
      end
    if (!mismatch) chk(1, "R6", "act", 0, 0);
    chk(pcnt == m_pcnt, "R7", "pcnt", pcnt, m_pcnt);
    for (int j = 0; j < NP; j++) e_mask[j] = m_pulse && (j < m_newcnt);
    chk(clr_data == m_pulse && set_pred == m_pulse && load_vl == m_pulse, "R9", "pulses",
        {clr_data, set_pred, load_vl}, {3{m_pulse}});
    chk(set_pred_mask == e_mask, "R9", "set_pred_mask", set_pred_mask, e_mask);
    iv = 0;
  endtask

  task automatic model_step();
    m_pulse = cnt_wr && (cnt_wdata <= NP);
    if (m_pulse) begin m_pcnt = cnt_wdata; m_newcnt = cnt_wdata; end
  endtask

  task automatic cyc(int v, int m, bit ps, logic [N-1:0] p0, logic [N-1:0] p1,
                     bit rd, bit wr, bit cw, int cd);
    @(negedge clk);
    vl = LW'(v); mvl = LW'(m); psel = ps; pred0 = p0; pred1 = p1;
    pred_rd = rd; pred_wr = wr; cnt_wr = cw; cnt_wdata = CW'(cd);
    #1;
    compare();
    model_step();
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state R7, R9
    cyc(0, 0, 0, '0, '0, 0, 0, 0, 0);
    // count 0: read first predicate gives ones (R8), second illegal (R8), write illegal (R8)
    cyc(10, 16, 0, 16'h0000, 16'h0000, 1, 0, 0, 0);
    cyc(10, 16, 1, 16'h0000, 16'hffff, 1, 0, 0, 0);
    cyc(10, 16, 0, 16'h0000, 16'h0000, 1, 1, 0, 0);
    // bad count writes R7, R10
    cyc(8, 12, 0, 16'hffff, 16'h0, 0, 0, 1, 9);
    cyc(8, 12, 0, 16'hffff, 16'h0, 0, 0, 1, 15);
    // legal write then pulse R9
    cyc(8, 12, 0, 16'h0, 16'h0, 0, 0, 1, 5);
    cyc(8, 12, 0, 16'h0, 16'h0, 0, 0, 0, 0);
    cyc(8, 12, 0, 16'h0, 16'h0, 0, 0, 1, 8);
    cyc(8, 12, 0, 16'h0, 16'h0, 0, 0, 1, 0);
    cyc(8, 12, 0, 16'h0, 16'h0, 0, 0, 1, 3);
    // predicated selection R1, R2, R6, tail R3
    cyc(12, 16, 0, 16'h5a5a, 16'h0f0f, 1, 0, 0, 0);
    cyc(12, 16, 1, 16'h5a5a, 16'h0f0f, 1, 0, 0, 0);
    // vl zero R4, mvl clamp R5
    cyc(0, 16, 0, 16'hffff, 16'hffff, 1, 0, 0, 0);
    cyc(16, 16, 1, 16'hffff, 16'hfffe, 1, 0, 0, 0);
    cyc(5, 7, 0, 16'hffff, 16'hffff, 0, 0, 0, 0);
    cyc(16, 31, 0, 16'h8001, 16'h0, 1, 1, 0, 0);
    for (int k = 0; k < 3000; k++) begin
      int m, v;
      m = $urandom_range(0, 31);
      v = $urandom_range(0, m);
      cyc(v, m, $urandom_range(0, 1), N'($urandom), N'($urandom),
          $urandom_range(0, 1), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 9) == 0), $urandom_range(0, 15));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule